// File: doc/BRIEF.md
# SMBus Indexed Block Configuration Register Slave

This block is a serial-bus target with one fixed 7-bit address that exposes a bank of seven 8-bit configuration bytes to a host. The bus lines SCL and SDA are brought into a faster system clock through a synchronizer. Edges of SCL, and START and STOP conditions, are found from the synchronized levels. Bytes are shifted MSB first. The slave pulls SDA low through an open-drain enable, both to acknowledge and to send read data.

Each write transfer carries a starting register offset, then a byte count, then the data bytes. The data bytes land in consecutive registers. A read transfer first sets the offset in a write phase. After a repeated START and the read address, the slave sends a byte count and then the register contents from that offset.

The register bank holds a mix of writable, read-only and reserved bits, each with a power-up value. An asynchronous active-low power-down/reset input puts every register back to that value. The bank's fields leave the block as plain control outputs for the neighbouring clock-control logic.

Top module: `smb_cfg_slave`

## Requirements
- R1: An address byte other than 0xD2 (write) or 0xD3 (read) is not acknowledged. SDA stays released for every later byte until the next START, and no register changes.
- R2: A write transfer 0xD2, offset, count N (N > 0), then N data bytes acknowledges every byte. Data byte k is written to register offset+k.
- R3: A count byte of 0 is not acknowledged. The data bytes that follow it in the same transfer are not acknowledged and write nothing.
- R4: In a write transfer, data bytes beyond the count N are not acknowledged and write nothing.
- R5: After 0xD2, an offset, a repeated START and 0xD3, the slave sends a count equal to 7 minus the offset. It then sends register offset, offset+1, and so on after each master ACK, with the index wrapping from 6 to 0. A master NACK ends the sending.
- R6: Write-enable masks per register are: 0 = 0xFF, 1 = 0xFF, 2 = 0xE0, 3 = 0xFE, 4 = 0x00, 5 = 0x00, 6 = 0x00. Masked-off bits ignore writes. Reserved bits read as 0. Register 6 always reads 0x03.
- R7: While pd_rst_n is low, and after it, the registers read 0x35, 0xF0, 0x80, 0x06, 0x00, 0x00, 0x03 for indices 0 to 6.
- R8: The outputs decode the registers as follows. Register 0 gives ssc_down_en = bit 7, sw_ctl_mode = bit 6, sw_out_en = bit 5, margin50 = bits 4:1 and oe_ck50_b = bit 0. Register 1 gives oe_ck32 = bit 7, oe_ck50_a = bit 6 and oe_cksel = bit 5. oe_diff = {register 1 bits 4:0, register 3 bits 7:1}. cksel_mode = register 2 bits 7:5.
- R9: An offset of 7 or more is treated as offset 0, for both writes and reads.
- R10: sda_oe changes only while SCL is low, apart from the release at START or STOP. It is low whenever the slave is idle or ignoring the bus.
- R11: During a write, the register index wraps from 6 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| pd_rst_n | input | 1 | Asynchronous active-low power-down/reset; restores register defaults |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| ssc_down_en | output | 1 | Spread-modulation enable field |
| sw_ctl_mode | output | 1 | Selects register control of global output enable |
| sw_out_en | output | 1 | Register-controlled global output enable |
| margin50 | output | 4 | Margin select for the 50 MHz outputs |
| oe_ck50_b | output | 1 | Enable for second 50 MHz output |
| oe_ck32 | output | 1 | Enable for 32.256 MHz output |
| oe_ck50_a | output | 1 | Enable for first 50 MHz output |
| oe_cksel | output | 1 | Enable for selectable-frequency output |
| oe_diff | output | 12 | Per-output enables for the differential 100 MHz clocks |
| cksel_mode | output | 3 | Frequency select for the selectable output |

## Verification
Some properties are checked by assertions on every cycle. SDA is never pulled while the slave is idle or ignoring the bus. The open-drain enable never moves while SCL is high, except when a START or STOP releases it. A register write strobe only follows a synchronized SCL rising edge inside an active transfer. The register bank never changes without such a strobe. Other behaviours can only be shown by the bench's bus scenarios: the decoding of addresses, offsets and counts, the ACK/NACK pattern for zero and excess counts, the wrap of the index on writes and reads, the per-bit write masks, and the restored defaults after a power-down pulse.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  localparam int NUM_REGS = 7;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int BYTE_W   = 8;
  localparam int BANK_W   = NUM_REGS * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_OFFS,
    ST_CNT,
    ST_WDAT,
    ST_RCNT,
    ST_RDAT,
    ST_IGN
  } link_st_t;

  // Power-up contents of each register
  function automatic logic [BYTE_W-1:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h35;
      1:       return 8'hF0;
      2:       return 8'h80;
      3:       return 8'h06;
      6:       return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  // Bits that a host write may change
  function automatic logic [BYTE_W-1:0] reg_wmask(input int idx);
    case (idx)
      0:       return 8'hFF;
      1:       return 8'hFF;
      2:       return 8'hE0;
      3:       return 8'hFE;
      default: return 8'h00;
    endcase
  endfunction

  // Offsets outside the map start at register 0
  function automatic logic [IDX_W-1:0] norm_index(input logic [BYTE_W-1:0] b);
    if (int'(b) < NUM_REGS) return IDX_W'(b);
    return '0;
  endfunction

  function automatic logic [IDX_W-1:0] next_index(input logic [IDX_W-1:0] i);
    if (int'(i) == NUM_REGS - 1) return '0;
    return i + 1'b1;
  endfunction

  // Number of registers from the index to the end of the map
  function automatic logic [BYTE_W-1:0] read_count(input logic [IDX_W-1:0] i);
    return BYTE_W'(NUM_REGS - int'(i));
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_ch;
  logic [STAGES-1:0] sda_ch;
  logic              scl_d;
  logic              sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ch <= '1;
          sda_ch <= '1;
        end else begin
          scl_ch <= scl_in;
          sda_ch <= sda_in;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ch <= '1;
          sda_ch <= '1;
        end else begin
          scl_ch <= {scl_ch[STAGES-2:0], scl_in};
          sda_ch <= {sda_ch[STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_lvl;
      sda_d <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_ch[STAGES-1];
  assign sda_lvl   = sda_ch[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BANK_W-1:0] regs_flat
);

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [BYTE_W-1:0] DEF  = reg_default(g);
      localparam logic [BYTE_W-1:0] MASK = reg_wmask(g);
      logic [BYTE_W-1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= DEF;
        end else if (wr_en && (wr_idx == IDX_W'(g))) begin
          q <= (q & ~MASK) | (wr_data & MASK);
        end
      end

      assign regs_flat[g*BYTE_W +: BYTE_W] = q;
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_idx == IDX_W'(k)) rd_data = regs_flat[k*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/smb_link_ctrl.sv
module smb_link_ctrl
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_lvl,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe,
  output logic              link_active
);

  localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};
  localparam logic [BYTE_W-1:0] ADDR_RD = {DEV_ADDR, 1'b1};
  localparam logic [3:0]        ACK_BIT = 4'd8;
  localparam logic [3:0]        LAST_DB = 4'd7;

  link_st_t          st;
  logic [3:0]        bit_cnt;
  logic [6:0]        shreg;
  logic [BYTE_W-1:0] txreg;
  logic [IDX_W-1:0]  ptr;
  logic [BYTE_W-1:0] remain;
  logic              ack_q;
  logic              tx_slot;
  logic [BYTE_W-1:0] byte_in;
  logic              byte_done;
  logic              ack_slot_end;

  assign byte_in      = {shreg, sda_lvl};
  assign byte_done    = scl_rise && (bit_cnt == LAST_DB) && !tx_slot;
  assign ack_slot_end = scl_rise && (bit_cnt == ACK_BIT);
  assign rd_idx       = ptr;
  assign link_active  = (st != ST_IDLE) && (st != ST_IGN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      txreg   <= '0;
      ptr     <= '0;
      remain  <= '0;
      ack_q   <= 1'b0;
      tx_slot <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_evt || start_evt) begin
        st      <= stop_evt ? ST_IDLE : ST_ADDR;
        bit_cnt <= '0;
        ack_q   <= 1'b0;
        tx_slot <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (scl_rise) begin
        if (bit_cnt != ACK_BIT) begin
          shreg   <= byte_in[6:0];
          bit_cnt <= bit_cnt + 4'd1;
          if (byte_done) begin
            ack_q <= 1'b0;
            case (st)
              ST_ADDR: begin
                if (byte_in == ADDR_WR) begin
                  ack_q <= 1'b1;
                  st    <= ST_OFFS;
                end else if (byte_in == ADDR_RD) begin
                  ack_q <= 1'b1;
                  st    <= ST_RCNT;
                end else begin
                  st <= ST_IGN;
                end
              end
              ST_OFFS: begin
                ack_q <= 1'b1;
                ptr   <= norm_index(byte_in);
                st    <= ST_CNT;
              end
              ST_CNT: begin
                if (byte_in == '0) begin
                  st <= ST_IGN;
                end else begin
                  ack_q  <= 1'b1;
                  remain <= byte_in;
                  st     <= ST_WDAT;
                end
              end
              ST_WDAT: begin
                if (remain != '0) begin
                  ack_q   <= 1'b1;
                  wr_en   <= 1'b1;
                  wr_idx  <= ptr;
                  wr_data <= byte_in;
                  ptr     <= next_index(ptr);
                  remain  <= remain - 8'd1;
                end else begin
                  st <= ST_IGN;
                end
              end
              default: ;
            endcase
          end
        end else begin
          // ninth clock of the slot: acknowledge bit on the bus
          bit_cnt <= '0;
          ack_q   <= 1'b0;
          if (tx_slot) begin
            if (!sda_lvl) begin
              txreg <= rd_data;
              ptr   <= next_index(ptr);
            end else begin
              tx_slot <= 1'b0;
              st      <= ST_IGN;
            end
          end else if (st == ST_RCNT) begin
            tx_slot <= 1'b1;
            txreg   <= read_count(ptr);
            st      <= ST_RDAT;
          end
        end
      end else if (scl_fall) begin
        if (bit_cnt == ACK_BIT) begin
          sda_oe <= tx_slot ? 1'b0 : ack_q;
        end else begin
          sda_oe <= tx_slot & ~txreg[3'd7 - bit_cnt[2:0]];
        end
      end
    end
  end

  // ack_slot_end is a named event for readability of the slot boundary
  logic unused_evt;
  assign unused_evt = ack_slot_end;

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       pd_rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  output logic       ssc_down_en,
  output logic       sw_ctl_mode,
  output logic       sw_out_en,
  output logic [3:0] margin50,
  output logic       oe_ck50_b,
  output logic       oe_ck32,
  output logic       oe_ck50_a,
  output logic       oe_cksel,
  output logic [11:0] oe_diff,
  output logic [2:0] cksel_mode
);

  logic              scl_lvl;
  logic              sda_lvl;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_evt;
  logic              stop_evt;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [IDX_W-1:0]  rd_idx;
  logic [BYTE_W-1:0] rd_data;
  logic [BANK_W-1:0] regs_flat;
  logic              link_active;

  smb_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst_n     (pd_rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  smb_link_ctrl #(.DEV_ADDR(DEV_ADDR)) link_i (
    .clk         (clk),
    .rst_n       (pd_rst_n),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_evt   (start_evt),
    .stop_evt    (stop_evt),
    .sda_lvl     (sda_lvl),
    .rd_data     (rd_data),
    .rd_idx      (rd_idx),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .sda_oe      (sda_oe),
    .link_active (link_active)
  );

  smb_reg_bank bank_i (
    .clk       (clk),
    .rst_n     (pd_rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .regs_flat (regs_flat)
  );

  logic [BYTE_W-1:0] r0, r1, r2, r3;
  assign r0 = regs_flat[0*BYTE_W +: BYTE_W];
  assign r1 = regs_flat[1*BYTE_W +: BYTE_W];
  assign r2 = regs_flat[2*BYTE_W +: BYTE_W];
  assign r3 = regs_flat[3*BYTE_W +: BYTE_W];

  assign ssc_down_en = r0[7];
  assign sw_ctl_mode = r0[6];
  assign sw_out_en   = r0[5];
  assign margin50    = r0[4:1];
  assign oe_ck50_b   = r0[0];
  assign oe_ck32     = r1[7];
  assign oe_ck50_a   = r1[6];
  assign oe_cksel    = r1[5];
  assign oe_diff     = {r1[4:0], r3[7:1]};
  assign cksel_mode  = r2[7:5];

  logic unused_bits;
  assign unused_bits = ^{r2[4:0], r3[0], scl_lvl};

endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk
  import smb_cfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_lvl,
  input logic              scl_rise,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              sda_oe,
  input logic              link_active,
  input logic              wr_en,
  input logic [BANK_W-1:0] regs_flat
);

  assert_oe_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !link_active |-> !sda_oe);

  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!scl_lvl || $past(start_evt || stop_evt)));

  assert_wr_after_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(scl_rise));

  assert_wr_in_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(link_active));

  assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(regs_flat));

endmodule

bind smb_cfg_slave smb_cfg_slave_chk chk_i (
  .clk         (clk),
  .rst_n       (pd_rst_n),
  .scl_lvl     (scl_lvl),
  .scl_rise    (scl_rise),
  .start_evt   (start_evt),
  .stop_evt    (stop_evt),
  .sda_oe      (sda_oe),
  .link_active (link_active),
  .wr_en       (wr_en),
  .regs_flat   (regs_flat)
);

// File: tb/smb_cfg_slave_tb_top.sv
module smb_cfg_slave_tb_top;

  localparam int Q = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic pd_rst_n = 1'b0;
  logic scl_m    = 1'b1;
  logic m_low    = 1'b0;
  logic sda_oe;
  logic sda_bus;
  assign sda_bus = ~(m_low | sda_oe);

  logic ssc_down_en, sw_ctl_mode, sw_out_en, oe_ck50_b, oe_ck32, oe_ck50_a, oe_cksel;
  logic [3:0]  margin50;
  logic [11:0] oe_diff;
  logic [2:0]  cksel_mode;

  smb_cfg_slave dut_i (
    .clk(clk), .pd_rst_n(pd_rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
    .ssc_down_en(ssc_down_en), .sw_ctl_mode(sw_ctl_mode), .sw_out_en(sw_out_en),
    .margin50(margin50), .oe_ck50_b(oe_ck50_b), .oe_ck32(oe_ck32), .oe_ck50_a(oe_ck50_a),
    .oe_cksel(oe_cksel), .oe_diff(oe_diff), .cksel_mode(cksel_mode)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;
  int  oe_viol = 0;

  logic [7:0] model [0:6];
  logic [7:0] wbuf  [0:9];
  bit         wack  [0:12];
  logic [7:0] rbuf  [0:9];
  logic [7:0] rcnt;
  bit         rack  [0:2];

  // R10 port monitor: the enable must not move while SCL is steadily high
  logic oe_prev = 1'b0;
  logic scl_prev = 1'b1;
  always @(posedge clk) begin
    if (pd_rst_n && scl_m && scl_prev && (sda_oe !== oe_prev)) oe_viol++;
    oe_prev  <= sda_oe;
    scl_prev <= scl_m;
  end

  function automatic logic [7:0] b_default(input int i);
    logic [7:0] t [0:6] = '{8'h35, 8'hF0, 8'h80, 8'h06, 8'h00, 8'h00, 8'h03};
    return t[i];
  endfunction

  function automatic logic [7:0] b_mask(input int i);
    logic [7:0] t [0:6] = '{8'hFF, 8'hFF, 8'hE0, 8'hFE, 8'h00, 8'h00, 8'h00};
    return t[i];
  endfunction

  function automatic int b_norm(input logic [7:0] off);
    return (off < 8'd7) ? int'(off) : 0;
  endfunction

  function automatic logic [25:0] exp_fields();
    logic [7:0] a, b, c, d;
    a = model[0]; b = model[1]; c = model[2]; d = model[3];
    return {a[7], a[6], a[5], a[4:1], a[0], b[7], b[6], b[5], b[4:0], d[7:1], c[7:5]};
  endfunction

  function automatic logic [25:0] act_fields();
    return {ssc_down_en, sw_ctl_mode, sw_out_en, margin50, oe_ck50_b, oe_ck32,
            oe_ck50_a, oe_cksel, oe_diff, cksel_mode};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    tick(Q); m_low = ~b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    tick(Q); m_low = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); b = sda_bus; tick(Q); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    m_low = 1'b0; scl_m = 1'b1; tick(Q); m_low = 1'b1; tick(Q); scl_m = 1'b0;
  endtask

  task automatic bus_rstart();
    tick(Q); m_low = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); m_low = 1'b1; tick(Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); m_low = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); m_low = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    acked = ~a;
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      bit_in(v);
      b[i] = v;
    end
    bit_out(~give_ack);
  endtask

  // address, offset, count, then n data bytes from wbuf; acks in wack
  task automatic do_write(input logic [7:0] adr, input logic [7:0] off,
                          input logic [7:0] cnt, input int n);
    bus_start();
    put_byte(adr, wack[0]);
    put_byte(off, wack[1]);
    put_byte(cnt, wack[2]);
    for (int i = 0; i < n; i++) put_byte(wbuf[i], wack[3+i]);
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] off, input int n);
    bus_start();
    put_byte(8'hD2, rack[0]);
    put_byte(off, rack[1]);
    bus_rstart();
    put_byte(8'hD3, rack[2]);
    get_byte(1'b1, rcnt);
    for (int i = 0; i < n; i++) get_byte(i != n-1, rbuf[i]);
    bus_stop();
  endtask

  task automatic model_write(input logic [7:0] off, input int n);
    int idx = b_norm(off);
    for (int i = 0; i < n; i++) begin
      model[idx] = (model[idx] & ~b_mask(idx)) | (wbuf[i] & b_mask(idx));
      idx = (idx + 1) % 7;
    end
  endtask

  // read n bytes from off and compare with the model (count, acks, wrap)
  task automatic read_check(input string tag, input logic [7:0] off, input int n);
    int idx = b_norm(off);
    do_read(off, n);
    chk({tag, " read acks"}, {29'd0, rack[0], rack[1], rack[2]}, 32'h7);
    chk({tag, " R5 count"}, {24'd0, rcnt}, 32'(7 - idx));
    for (int i = 0; i < n; i++) begin
      chk($sformatf("%s R5 byte idx %0d", tag, idx), {24'd0, rbuf[i]}, {24'd0, model[idx]});
      idx = (idx + 1) % 7;
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 7; i++) model[i] = b_default(i);
    chk("R10 idle release", {31'd0, sda_oe}, 32'd0);
    chk("R7 R8 default fields", {6'd0, act_fields()}, {6'd0, exp_fields()});
    chk("R7 default oe_diff", {20'd0, oe_diff}, 32'h803);
    read_check("R7 defaults", 8'd0, 7);
  endtask

  task automatic t_write_fields();
    wbuf[0] = 8'h9A; wbuf[1] = 8'h2B; wbuf[2] = 8'h60; wbuf[3] = 8'hD4;
    do_write(8'hD2, 8'd0, 8'd4, 4);
    model_write(8'd0, 4);
    for (int i = 0; i < 7; i++) chk($sformatf("R2 write ack %0d", i), {31'd0, wack[i]}, 32'd1);
    chk("R8 decoded fields", {6'd0, act_fields()}, {6'd0, exp_fields()});
    chk("R8 oe_diff value", {20'd0, oe_diff}, 32'h5EA);
    read_check("R2 readback", 8'd0, 4);
  endtask

  task automatic t_masks();
    for (int i = 0; i < 5; i++) wbuf[i] = 8'hFF;
    do_write(8'hD2, 8'd2, 8'd5, 5);
    model_write(8'd2, 5);
    chk("R6 all acked", {27'd0, wack[3], wack[4], wack[5], wack[6], wack[7]}, 32'h1F);
    read_check("R6 masks", 8'd2, 5);
    chk("R6 reg2 value", {24'd0, model[2]}, 32'hE0);
  endtask

  task automatic t_wrap_write();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(8'hD2, 8'd5, 8'd3, 3);
    model_write(8'd5, 3);
    chk("R11 wrap acks", {29'd0, wack[3], wack[4], wack[5]}, 32'h7);
    chk("R11 reg0 from wrap", {24'd0, model[0]}, 32'h33);
    read_check("R11 wrap", 8'd0, 1);
  endtask

  task automatic t_zero_count();
    wbuf[0] = 8'h00; wbuf[1] = 8'h12;
    do_write(8'hD2, 8'd1, 8'd0, 2);
    chk("R3 zero count acks", {27'd0, wack[0], wack[1], wack[2], wack[3], wack[4]}, 32'h18);
    read_check("R3 unchanged", 8'd1, 1);
  endtask

  task automatic t_over_count();
    wbuf[0] = 8'h50; wbuf[1] = 8'h99;
    do_write(8'hD2, 8'd3, 8'd1, 2);
    model_write(8'd3, 1);
    chk("R4 excess acks", {28'd0, wack[1], wack[2], wack[3], wack[4]}, 32'hE);
    read_check("R4 unchanged", 8'd3, 2);
  endtask

  task automatic t_bad_addr();
    wbuf[0] = 8'h01; wbuf[1] = 8'h77;
    do_write(8'hA4, 8'd1, 8'd1, 2);
    chk("R1 foreign address acks", {27'd0, wack[0], wack[1], wack[2], wack[3], wack[4]}, 32'h0);
    do_write(8'hD0, 8'd1, 8'd1, 2);
    chk("R1 near address acks", {27'd0, wack[0], wack[1], wack[2], wack[3], wack[4]}, 32'h0);
    chk("R1 fields unchanged", {6'd0, act_fields()}, {6'd0, exp_fields()});
  endtask

  task automatic t_read_wrap();
    read_check("R5 wrap", 8'd4, 5);
  endtask

  task automatic t_big_offset();
    read_check("R9 read", 8'd10, 2);
    wbuf[0] = 8'hC0;
    do_write(8'hD2, 8'd9, 8'd1, 1);
    model_write(8'd9, 1);
    chk("R9 write lands in reg0", {24'd0, model[0]}, 32'hC0);
    chk("R9 fields", {6'd0, act_fields()}, {6'd0, exp_fields()});
  endtask

  task automatic t_power_down();
    tick(3); pd_rst_n = 1'b0; tick(10);
    for (int i = 0; i < 7; i++) model[i] = b_default(i);
    chk("R7 fields in reset", {6'd0, act_fields()}, {6'd0, exp_fields()});
    pd_rst_n = 1'b1; tick(10);
    read_check("R7 after reset", 8'd0, 7);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    tick(8);
    pd_rst_n = 1'b1;
    tick(8);
    t_reset();
    t_write_fields();
    t_masks();
    t_wrap_write();
    t_zero_count();
    t_over_count();
    t_bad_addr();
    t_read_wrap();
    t_big_offset();
    t_power_down();
    tick(4);
    chk("R10 no change while SCL high", 32'(oe_viol), 32'd0);
    chk("R10 released at end", {31'd0, sda_oe}, 32'd0);
    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end

endmodule